// File: doc/BRIEF.md
# Source-Routed Mesh Router Input Stage

This block sits on one input link of a five-port mesh router node. Each incoming 34-bit flit arrives with a virtual-channel tag (0 or 1) and is placed in a single-entry holding register for that channel. A flit that opens a packet carries its route as a list of 2-bit direction codes in its low 18 bits. The block takes the lowest code as the outgoing direction, shifts the list down by one code so the next hop finds its own direction at the bottom, and keeps the chosen direction per channel for the rest of the packet. Every later flit of that packet follows the stored direction unchanged.

On the output side, each channel offers its held flit on a data bus shared by all four destinations. A valid/ready pair for each (channel, destination) combination marks which destination should take it. A packet-start strobe goes with the opening flit for the selected destination, and a packet-end level goes with the closing flit. A channel refuses new input until its held flit has been taken. This rule keeps at most one flit per channel in flight, so a second notification can never reach a destination before the first one is consumed. A continuation flit that arrives on a channel with no open packet is discarded, and a sticky error output is raised.

Top module: `flit_steer_unit`

## Requirements
- R1: After a synchronous active-low reset, every `dst_valid`, `dst_bop` and `dst_eop` bit is low, both `in_ready` bits are high, and `orphan_err` is low.
- R2: A flit with bit 33 set (packet start) on channel v is offered to destination d = bits 1:0 of the flit. It appears on `dst_valid[v*4+d]` in the cycle after it is accepted.
- R3: A packet-start flit is presented on `dst_data[v*34 +: 34]` with bits 17:0 replaced by {2'b00, bits 17:2}. Bits 33:18 are unchanged.
- R4: A flit with bit 33 clear on a channel with an open packet is presented with all 34 bits unchanged. It goes to the direction stored from that channel's latest packet-start flit.
- R5: The `in_vc` input selects the channel that stores the flit. Both channels can hold flits at the same time, and each is offered and taken independently of the other.
- R6: At most one `dst_valid` bit per channel is high. `dst_bop[v*4+d]` is high only together with `dst_valid[v*4+d]` for a packet-start flit. `dst_eop[v]` is high while channel v offers a flit with bit 32 (packet end) set.
- R7: While channel v holds a flit, `in_ready[v]` is low. An offered flit and its valid bit stay unchanged until the selected destination's ready is high. A new flit presented in that time is not taken.
- R8: A flit with both bits 33 and 32 set is a complete one-flit packet. It is routed as a packet start and leaves no packet open on its channel.
- R9: A flit with bit 33 clear on a channel with no open packet is accepted and discarded. It raises no valid bit, and `orphan_err` goes high and stays high until reset.
- R10: Ready from a destination other than the selected one does not remove the held flit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Incoming flit present |
| in_vc | input | 1 | Channel tag of the incoming flit |
| in_flit | input | 34 | Incoming flit |
| in_ready | output | 2 | Per-channel acceptance; a flit is taken when in_valid and in_ready[in_vc] are high |
| dst_valid | output | 8 | Flit offered, index v*4+d |
| dst_ready | input | 8 | Destination takes the flit, index v*4+d |
| dst_bop | output | 8 | Packet-start strobe, index v*4+d |
| dst_eop | output | 2 | Packet-end level per channel |
| dst_data | output | 68 | Held flit per channel, slice v*34 +: 34 |
| orphan_err | output | 1 | Sticky flag for discarded stray continuation flits |

## Verification
The hardest situation to reach from the ports is a new flit arriving on a channel whose previous flit is still waiting. The wait may be caused by no ready at all or by ready from the wrong destination. The bench holds one channel's flit by raising ready only on a different destination of that channel. During that time it presents a fresh flit on the same channel, then checks that the offered data, the valid position and `in_ready` have not moved. It also reaches the stray-continuation case in two ways: directly after a one-flit packet, and after a normal packet has closed.

// File: rtl/noc_ic_pkg.sv
// Shared types for the router input stage.
// Assumes flits carry packet-start in the top bit and packet-end just below it.
package noc_ic_pkg;
    typedef enum logic [1:0] {
        ACT_IDLE = 2'd0,
        ACT_HEAD = 2'd1,
        ACT_BODY = 2'd2,
        ACT_DROP = 2'd3
    } lane_act_e;
endpackage

// File: rtl/flit_rewrite.sv
// Pure combinational decode of an incoming flit: packet flags, next-hop
// direction, and the header with its route list shifted one code down.
// Assumes the route list occupies the low PATH_W bits.
module flit_rewrite #(
    parameter int FLIT_W = 34,
    parameter int PATH_W = 18,
    parameter int DIR_W  = 2
) (
    input  logic [FLIT_W-1:0] flit_in,
    output logic              is_bop,
    output logic              is_eop,
    output logic [DIR_W-1:0]  next_dir,
    output logic [FLIT_W-1:0] hdr_out
);
    // Decode flags, pick direction, shift route list with zero fill.
    always_comb begin
        is_bop   = flit_in[FLIT_W-1];
        is_eop   = flit_in[FLIT_W-2];
        next_dir = flit_in[DIR_W-1:0];
        hdr_out  = {flit_in[FLIT_W-1:PATH_W], {DIR_W{1'b0}}, flit_in[PATH_W-1:DIR_W]};
    end
endmodule

// File: rtl/dest_fanout.sv
// Turns a held flit and its direction into one-hot per-destination valid and
// packet-start strobes, and gathers the selected destination's ready.
// Assumes dir < NUM_DIR.
module dest_fanout #(
    parameter int NUM_DIR = 4,
    parameter int DIR_W   = 2
) (
    input  logic               occupied,
    input  logic               is_hdr,
    input  logic [DIR_W-1:0]   dir,
    input  logic [NUM_DIR-1:0] ready_vec,
    output logic [NUM_DIR-1:0] valid_vec,
    output logic [NUM_DIR-1:0] bop_vec,
    output logic               take
);
    for (genvar d = 0; d < NUM_DIR; d++) begin : g_dst
        // One destination slot: raised only when it is the selected direction.
        always_comb begin
            valid_vec[d] = occupied && (dir == DIR_W'(d));
            bop_vec[d]   = valid_vec[d] && is_hdr;
        end
    end

    // A flit leaves only on ready from its own destination.
    always_comb take = |(valid_vec & ready_vec);
endmodule

// File: rtl/vc_lane.sv
// One virtual-channel lane: single-entry hold register, per-packet route
// memory and stray-continuation detection. Accepts a flit only when empty,
// so a new notification never precedes consumption of the previous one.
module vc_lane
    import noc_ic_pkg::*;
#(
    parameter int FLIT_W  = 34,
    parameter int PATH_W  = 18,
    parameter int NUM_DIR = 4,
    parameter int DIR_W   = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_valid,
    input  logic [FLIT_W-1:0]  wr_flit,
    output logic               wr_ready,
    input  logic [NUM_DIR-1:0] dst_ready,
    output logic [NUM_DIR-1:0] dst_valid,
    output logic [NUM_DIR-1:0] dst_bop,
    output logic               rd_eop,
    output logic [FLIT_W-1:0]  rd_flit,
    output logic               orphan_err
);
    logic              buf_full;
    logic [FLIT_W-1:0] buf_flit;
    logic [DIR_W-1:0]  buf_dir;
    logic              buf_hdr;
    logic              pkt_open;
    logic [DIR_W-1:0]  route_dir;
    logic              err_q;

    logic              in_bop, in_eop, take;
    logic [DIR_W-1:0]  in_dir;
    logic [FLIT_W-1:0] in_hdr;
    lane_act_e         act;

    flit_rewrite #(.FLIT_W(FLIT_W), .PATH_W(PATH_W), .DIR_W(DIR_W)) u_rw (
        .flit_in (wr_flit),
        .is_bop  (in_bop),
        .is_eop  (in_eop),
        .next_dir(in_dir),
        .hdr_out (in_hdr)
    );

    dest_fanout #(.NUM_DIR(NUM_DIR), .DIR_W(DIR_W)) u_fan (
        .occupied (buf_full),
        .is_hdr   (buf_hdr),
        .dir      (buf_dir),
        .ready_vec(dst_ready),
        .valid_vec(dst_valid),
        .bop_vec  (dst_bop),
        .take     (take)
    );

    // Classify what an arriving flit does to this lane.
    always_comb begin
        if (!wr_valid || buf_full) act = ACT_IDLE;
        else if (in_bop)           act = ACT_HEAD;
        else if (pkt_open)         act = ACT_BODY;
        else                       act = ACT_DROP;
    end

    // Lane outputs driven straight from held state.
    always_comb begin
        wr_ready   = !buf_full;
        rd_flit    = buf_flit;
        rd_eop     = buf_full && buf_flit[FLIT_W-2];
        orphan_err = err_q;
    end

    // Hold register, route memory and error flag update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_full  <= 1'b0;
            buf_flit  <= '0;
            buf_dir   <= '0;
            buf_hdr   <= 1'b0;
            pkt_open  <= 1'b0;
            route_dir <= '0;
            err_q     <= 1'b0;
        end else begin
            if (take) buf_full <= 1'b0;
            case (act)
                ACT_HEAD: begin
                    buf_full  <= 1'b1;
                    buf_flit  <= in_hdr;
                    buf_dir   <= in_dir;
                    buf_hdr   <= 1'b1;
                    pkt_open  <= !in_eop;
                    route_dir <= in_eop ? '0 : in_dir;
                end
                ACT_BODY: begin
                    buf_full <= 1'b1;
                    buf_flit <= wr_flit;
                    buf_dir  <= route_dir;
                    buf_hdr  <= 1'b0;
                    if (in_eop) pkt_open <= 1'b0;
                end
                ACT_DROP: err_q <= 1'b1;
                default: ;
            endcase
        end
    end

    AST_ONE_DEST: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dst_valid)); // R6
    AST_BOP_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (|dst_bop) |-> ((dst_bop & ~dst_valid) == '0)); // R6
    AST_HOLD_UNTIL_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        ((|dst_valid) && ((dst_valid & dst_ready) == '0)) |=> ($stable(rd_flit) && $stable(dst_valid))); // R7
    AST_NO_OVERWRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_ready) |=> $stable(rd_flit)); // R7
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        orphan_err |=> orphan_err); // R9
endmodule

// File: rtl/flit_steer_unit.sv
// Input stage of a mesh router port: splits flits into per-channel lanes by
// their channel tag, and exposes per (channel, destination) valid/ready,
// packet-start strobes, per-channel packet-end levels and held data.
// Assumes the upstream link respects in_ready per channel.
module flit_steer_unit #(
    parameter int FLIT_W  = 34,
    parameter int PATH_W  = 18,
    parameter int NUM_VC  = 2,
    parameter int NUM_DIR = 4,
    localparam int DIR_W  = $clog2(NUM_DIR),
    localparam int VC_W   = (NUM_VC > 1) ? $clog2(NUM_VC) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      in_valid,
    input  logic [VC_W-1:0]           in_vc,
    input  logic [FLIT_W-1:0]         in_flit,
    output logic [NUM_VC-1:0]         in_ready,
    output logic [NUM_VC*NUM_DIR-1:0] dst_valid,
    input  logic [NUM_VC*NUM_DIR-1:0] dst_ready,
    output logic [NUM_VC*NUM_DIR-1:0] dst_bop,
    output logic [NUM_VC-1:0]         dst_eop,
    output logic [NUM_VC*FLIT_W-1:0]  dst_data,
    output logic                      orphan_err
);
    logic [NUM_VC-1:0] lane_err;
    logic [NUM_VC-1:0] lane_wr;

    for (genvar v = 0; v < NUM_VC; v++) begin : g_vc
        // Steer the arriving flit to the lane named by its tag.
        always_comb lane_wr[v] = in_valid && (in_vc == VC_W'(v));

        vc_lane #(
            .FLIT_W(FLIT_W), .PATH_W(PATH_W), .NUM_DIR(NUM_DIR), .DIR_W(DIR_W)
        ) u_lane (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_valid  (lane_wr[v]),
            .wr_flit   (in_flit),
            .wr_ready  (in_ready[v]),
            .dst_ready (dst_ready[v*NUM_DIR +: NUM_DIR]),
            .dst_valid (dst_valid[v*NUM_DIR +: NUM_DIR]),
            .dst_bop   (dst_bop[v*NUM_DIR +: NUM_DIR]),
            .rd_eop    (dst_eop[v]),
            .rd_flit   (dst_data[v*FLIT_W +: FLIT_W]),
            .orphan_err(lane_err[v])
        );
    end

    // Any lane that saw a stray continuation flags the port.
    always_comb orphan_err = |lane_err;
endmodule

// File: tb/tb_flit_steer_unit.sv
module tb_flit_steer_unit;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [0:0]  in_vc;
    logic [33:0] in_flit;
    logic [1:0]  in_ready;
    logic [7:0]  dst_valid, dst_ready, dst_bop;
    logic [1:0]  dst_eop;
    logic [67:0] dst_data;
    logic        orphan_err;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    flit_steer_unit dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_vc(in_vc),
        .in_flit(in_flit), .in_ready(in_ready), .dst_valid(dst_valid),
        .dst_ready(dst_ready), .dst_bop(dst_bop), .dst_eop(dst_eop),
        .dst_data(dst_data), .orphan_err(orphan_err)
    );

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [33:0] mk(input bit b, input bit e, input logic [31:0] p);
        return {b, e, p};
    endfunction

    function automatic logic [33:0] shifted(input logic [33:0] f);
        return {f[33:18], 2'b00, f[17:2]};
    endfunction

    task automatic send(input bit vc, input logic [33:0] f);
        @(negedge clk);
        in_valid = 1'b1; in_vc = vc; in_flit = f;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic pop(input int idx);
        @(negedge clk);
        dst_ready[idx] = 1'b1;
        @(negedge clk);
        dst_ready = '0;
    endtask

    task automatic t_reset;
        rst_n = 1'b0; in_valid = 1'b0; in_vc = '0; in_flit = '0; dst_ready = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(dst_valid == 0 && dst_bop == 0 && dst_eop == 0, "R1 outputs idle", {dst_valid, dst_bop}, 0);
        check(in_ready == 2'b11 && !orphan_err, "R1 ready/err", {in_ready, orphan_err}, 3'b110);
    endtask

    task automatic t_header_and_hold;
        logic [33:0] h = mk(1, 0, 32'hABCD_2E76); // dir = 2'b10
        send(0, h);
        check(dst_valid == 8'b0000_0100, "R2 header dir", dst_valid, 8'b0000_0100);
        check(dst_bop == 8'b0000_0100, "R6 bop with header", dst_bop, 8'b0000_0100);
        check(dst_data[33:0] == shifted(h), "R3 header rewrite", dst_data[33:0], shifted(h));
        check(in_ready[0] == 1'b0, "R7 ready low when full", in_ready, 2'b10);
        // wrong-destination ready plus a fresh flit on the same channel
        @(negedge clk);
        dst_ready[1] = 1'b1; in_valid = 1'b1; in_vc = 0; in_flit = mk(1, 0, 32'h1111_1111);
        @(negedge clk);
        dst_ready = '0; in_valid = 1'b0;
        check(dst_valid == 8'b0000_0100, "R10 wrong ready keeps flit", dst_valid, 8'b0000_0100);
        check(dst_data[33:0] == shifted(h), "R7 no overwrite", dst_data[33:0], shifted(h));
        pop(2);
        check(dst_valid == 0 && in_ready[0], "R7 released after take", {dst_valid, in_ready}, 10'b1);
    endtask

    task automatic t_body_tail;
        logic [33:0] b = mk(0, 0, 32'h0000_0003);
        logic [33:0] t = mk(0, 1, 32'h5555_0001);
        send(0, b);
        check(dst_valid == 8'b0000_0100 && dst_bop == 0, "R4 body latched dir", dst_valid, 8'b0000_0100);
        check(dst_data[33:0] == b, "R4 body unchanged", dst_data[33:0], b);
        check(dst_eop == 0, "R6 no eop on body", dst_eop, 0);
        pop(2);
        send(0, t);
        check(dst_valid == 8'b0000_0100 && dst_eop == 2'b01, "R6 eop on tail", {dst_valid, dst_eop}, 10'b0000_0100_01);
        pop(2);
    endtask

    task automatic t_single_flit;
        logic [33:0] s = mk(1, 1, 32'h0000_0001); // dir 1
        send(1, s);
        check(dst_valid == 8'b0010_0000, "R8 single routed", dst_valid, 8'b0010_0000);
        check(dst_bop == 8'b0010_0000 && dst_eop == 2'b10, "R8 single bop+eop", {dst_bop, dst_eop}, 10'b0010_0000_10);
        check(dst_data[67:34] == shifted(s), "R3 single rewrite", dst_data[67:34], shifted(s));
        pop(5);
        check(!orphan_err, "R9 no error yet", orphan_err, 0);
        send(1, mk(0, 0, 32'h0000_0002));
        check(dst_valid == 0 && in_ready == 2'b11, "R8 body after single dropped", {dst_valid, in_ready}, 10'b11);
        check(orphan_err, "R9 orphan flag", orphan_err, 1);
    endtask

    task automatic t_two_vc;
        logic [33:0] h0 = mk(1, 0, 32'h0000_0003); // vc0 dir3
        logic [33:0] h1 = mk(1, 0, 32'h0000_0000); // vc1 dir0
        send(0, h0);
        send(1, h1);
        check(dst_valid == 8'b0001_1000, "R5 both channels held", dst_valid, 8'b0001_1000);
        check(in_ready == 2'b00, "R5 both ready low", in_ready, 0);
        pop(4);
        check(dst_valid == 8'b0000_1000, "R5 vc1 taken alone", dst_valid, 8'b0000_1000);
        send(1, mk(0, 1, 32'hCAFE_0000));
        check(dst_valid == 8'b0001_1000 && dst_data[67:34] == mk(0, 1, 32'hCAFE_0000), "R4 vc1 body own route", dst_valid, 8'b0001_1000);
        pop(3); pop(4);
        check(dst_valid == 0, "R5 all drained", dst_valid, 0);
        // stray body after closed packet on vc0 - vc0 still open so close first
        send(0, mk(0, 1, 32'h0));
        pop(3);
        send(0, mk(0, 0, 32'h7));
        check(dst_valid == 0 && orphan_err, "R9 orphan after closed packet, sticky", {dst_valid, orphan_err}, 9'b1);
    endtask

    initial begin
        t_reset();
        t_header_and_hold();
        t_body_tail();
        t_single_flit();
        t_two_vc();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule